// File: doc/BRIEF.md
# Selectable Transmit Bit Clock Source

This block supplies the transmit bit clock for one line channel and launches the positive and negative data rails against it. A mode input selects the clock source. When it is low, the block divides a fast reference clock by a ratio picked with a 3-bit rate code, drives the result out and raises the pad output enable. When it is high, the pad is released and the block accepts a bit clock supplied from outside. That clock is synchronised into the reference domain and used in the same way as the internal one.

An edge-select input picks the clock edge on which the data rails must be valid, and the rule is the same for both sources. The block updates the rails one reference cycle after it observes the opposite clock edge, so they are steady at the edge that was chosen. It pulses a strobe in that same cycle so that upstream logic can present the next symbol. While the external source is in use, a frequency checker counts that clock's rising edges over a window of a fixed number of nominal bit periods. It raises an alarm when the count leaves the band allowed by a 250 ppm limit plus one count of quantisation slack. A change of rate code or mode restarts the divider and the checker window together.

Top module: `tx_clk_source`

## Requirements
- R1: In internal mode, with default parameters, rate code c from 0 to 5 gives a tclk_out period of 4·2^c reference cycles at 50 % duty.
- R2: Rate codes 6 and 7 give the same clock period and checker window as code 5, the slowest rate.
- R3: tclk_oe equals the inverse of ext_mode sampled at the previous clock edge. tclk_out stays low whenever tclk_oe is low.
- R4: In internal mode, tpos/tneg change exactly one reference cycle after a tclk_out transition to the launch level. The launch level is low when valid_on_fall = 0 (data valid at the rising edge) and high when valid_on_fall = 1. At no other time do they change.
- R5: In external mode the same edge rule applies to ext_clk_in. tpos/tneg change SYNC_STAGES+1 (default 3) reference cycles after the input moves to the launch level.
- R6: bit_take is high for exactly the cycles in which tpos/tneg take new values from data_pos/data_neg.
- R7: In external mode, at the end of each window of WIN_PERIODS nominal periods, freq_alarm is set when the counted rising edges fall outside WIN_PERIODS ± S and cleared when they fall inside. S = ceil(WIN_PERIODS·250/10^6) + 1.
- R8: freq_alarm is low at all times in internal mode, whatever ext_clk_in does.
- R9: Any change of the raw rate_sel value or of ext_mode restarts the block. tclk_out drops low, the next rising edge comes half a period later, freq_alarm clears and a new window starts. A window end that falls in the restart cycle is discarded.
- R10: While rst is high, tclk_out, tclk_oe, tpos, tneg, bit_take and freq_alarm are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0: generate the bit clock, 1: accept an external one |
| rate_sel | input | RATE_W | Rate code that selects the divide ratio and the nominal external rate |
| valid_on_fall | input | 1 | 0: data valid at the rising edge, 1: data valid at the falling edge |
| ext_clk_in | input | 1 | External bit clock, asynchronous |
| data_pos | input | 1 | Next positive-rail symbol |
| data_neg | input | 1 | Next negative-rail symbol |
| tclk_out | output | 1 | Generated bit clock toward the pad |
| tclk_oe | output | 1 | Pad output enable for the bit clock |
| tpos | output | 1 | Launched positive rail |
| tneg | output | 1 | Launched negative rail |
| bit_take | output | 1 | One-cycle strobe when a new symbol is launched |
| freq_alarm | output | 1 | External clock outside the allowed frequency band |

## Verification
A configuration restart and the close of a checker window can fall on the same reference edge. The bench provokes this by feeding a clearly out-of-band external clock, confirming that the alarm rises while the configuration is held, then switching rate_sel between 6 and 7 every window length. Both codes map to the slowest rate, so each restart lands exactly on the edge where a window would close. The restart must win every time, and freq_alarm must stay low over several such windows.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Rate codes above the last table entry fold onto the slowest rate.
  function automatic int unsigned txc_eff_code(input int unsigned code, input int unsigned n_rates);
    return (code >= n_rates) ? (n_rates - 1) : code;
  endfunction

  function automatic int unsigned txc_half_period(input int unsigned code, input int unsigned base_half,
                                                  input int unsigned n_rates);
    return base_half << txc_eff_code(code, n_rates);
  endfunction

  function automatic int unsigned txc_window(input int unsigned code, input int unsigned base_half,
                                             input int unsigned n_rates, input int unsigned periods);
    return periods * 2 * txc_half_period(code, base_half, n_rates);
  endfunction

  // ppm allowance rounded up, plus one count for window quantisation.
  function automatic int unsigned txc_slack(input int unsigned expected, input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(expected) * longint'(ppm);
    return int'((prod + 64'd999999) / 64'd1000000) + 1;
  endfunction

endpackage

// File: rtl/txc_rate_div.sv
module txc_rate_div
  import txc_pkg::*;
#(
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned NUM_RATES = 6,
  parameter int unsigned BASE_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_code,
  output logic              clk_lvl
);

  localparam int unsigned MAX_HALF = BASE_HALF << (NUM_RATES - 1);
  localparam int          CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;

  always_comb half_m1 = CW'(txc_half_period(32'(rate_code), BASE_HALF, NUM_RATES) - 1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q   <= '0;
      clk_lvl <= 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_q   <= '0;
      clk_lvl <= ~clk_lvl;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: the phase counter never passes the terminal count of the selected rate
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst) cnt_q <= half_m1);

endmodule

// File: rtl/txc_clk_sel.sv
module txc_clk_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic use_ext,
  input  logic gen_clk,
  input  logic mask,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sel;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_clk;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      end
    end
  endgenerate

  always_comb begin
    sel  = use_ext ? sync_q[SYNC_STAGES-1] : gen_clk;
    rise = !mask && sel && !prev_q;
    fall = !mask && !sel && prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel;
  end

endmodule

// File: rtl/txc_launch.sv
module txc_launch (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  input  logic valid_on_fall,
  input  logic d_pos,
  input  logic d_neg,
  output logic q_pos,
  output logic q_neg,
  output logic take
);

  logic launch;

  // Data moves on the edge opposite to the one it must be valid on.
  always_comb launch = valid_on_fall ? rise : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_pos <= 1'b0;
      q_neg <= 1'b0;
      take  <= 1'b0;
    end else begin
      take <= launch;
      if (launch) begin
        q_pos <= d_pos;
        q_neg <= d_neg;
      end
    end
  end

  // R6: the rails hold whenever no launch strobe is shown
  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !take |-> ($stable(q_pos) && $stable(q_neg)));

endmodule

// File: rtl/txc_freq_chk.sv
module txc_freq_chk
  import txc_pkg::*;
#(
  parameter int unsigned RATE_W      = 3,
  parameter int unsigned NUM_RATES   = 6,
  parameter int unsigned BASE_HALF   = 2,
  parameter int unsigned WIN_PERIODS = 4000,
  parameter int unsigned PPM_LIMIT   = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rise,
  output logic              out_of_tol
);

  localparam int unsigned MAX_WIN = WIN_PERIODS * 2 * (BASE_HALF << (NUM_RATES - 1));
  localparam int          WW      = $clog2(MAX_WIN + 1);
  localparam int unsigned SLACK   = txc_slack(WIN_PERIODS, PPM_LIMIT);
  localparam int unsigned LO_CNT  = (WIN_PERIODS > SLACK) ? (WIN_PERIODS - SLACK) : 0;
  localparam int unsigned HI_CNT  = WIN_PERIODS + SLACK;

  logic [WW-1:0] win_q;
  logic [WW-1:0] edges_q;
  logic [WW-1:0] win_last;
  logic [WW-1:0] total;

  always_comb begin
    win_last = WW'(txc_window(32'(rate_code), BASE_HALF, NUM_RATES, WIN_PERIODS) - 1);
    total    = edges_q + WW'(rise);
  end

  // Restart has priority over a window that closes in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      win_q      <= '0;
      edges_q    <= '0;
      out_of_tol <= 1'b0;
    end else if (win_q == win_last) begin
      win_q      <= '0;
      edges_q    <= '0;
      out_of_tol <= (total < WW'(LO_CNT)) || (total > WW'(HI_CNT));
    end else begin
      win_q   <= win_q + 1'b1;
      edges_q <= total;
    end
  end

  // R7: the window position stays inside the window of the selected rate
  p_win_range_r7: assert property (@(posedge clk) disable iff (rst) win_q <= win_last);

  // R8: leaving external mode clears the alarm on the next edge
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst) !active |=> !out_of_tol);

  // R9: a restart discards any window result and starts a fresh window
  p_restart_wins_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out_of_tol && win_q == '0));

endmodule

// File: rtl/tx_clk_source.sv
module tx_clk_source #(
  parameter int unsigned RATE_W      = 3,
  parameter int unsigned NUM_RATES   = 6,
  parameter int unsigned BASE_HALF   = 2,
  parameter int unsigned WIN_PERIODS = 4000,
  parameter int unsigned PPM_LIMIT   = 250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              valid_on_fall,
  input  logic              ext_clk_in,
  input  logic              data_pos,
  input  logic              data_neg,
  output logic              tclk_out,
  output logic              tclk_oe,
  output logic              tpos,
  output logic              tneg,
  output logic              bit_take,
  output logic              freq_alarm
);

  logic [RATE_W-1:0] rate_q;
  logic              mode_q;
  logic              restart;
  logic              restart_d;
  logic              edge_mask;
  logic              gen_lvl;
  logic              clk_rise;
  logic              clk_fall;

  always_comb begin
    restart   = !rst && ((rate_sel != rate_q) || (ext_mode != mode_q));
    edge_mask = restart || restart_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q    <= '0;
      mode_q    <= 1'b0;
      restart_d <= 1'b0;
      tclk_oe   <= 1'b0;
    end else begin
      rate_q    <= rate_sel;
      mode_q    <= ext_mode;
      restart_d <= restart;
      tclk_oe   <= !ext_mode;
    end
  end

  txc_rate_div #(
    .RATE_W   (RATE_W),
    .NUM_RATES(NUM_RATES),
    .BASE_HALF(BASE_HALF)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (!mode_q),
    .restart  (restart),
    .rate_code(rate_q),
    .clk_lvl  (gen_lvl)
  );

  assign tclk_out = gen_lvl;

  txc_clk_sel #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk    (clk),
    .rst    (rst),
    .ext_clk(ext_clk_in),
    .use_ext(mode_q),
    .gen_clk(gen_lvl),
    .mask   (edge_mask),
    .rise   (clk_rise),
    .fall   (clk_fall)
  );

  txc_launch u_launch (
    .clk          (clk),
    .rst          (rst),
    .rise         (clk_rise),
    .fall         (clk_fall),
    .valid_on_fall(valid_on_fall),
    .d_pos        (data_pos),
    .d_neg        (data_neg),
    .q_pos        (tpos),
    .q_neg        (tneg),
    .take         (bit_take)
  );

  txc_freq_chk #(
    .RATE_W     (RATE_W),
    .NUM_RATES  (NUM_RATES),
    .BASE_HALF  (BASE_HALF),
    .WIN_PERIODS(WIN_PERIODS),
    .PPM_LIMIT  (PPM_LIMIT)
  ) u_chk (
    .clk       (clk),
    .rst       (rst),
    .active    (mode_q),
    .restart   (restart),
    .rate_code (rate_q),
    .rise      (clk_rise),
    .out_of_tol(freq_alarm)
  );

  // R3: the enable follows the mode input with one register of delay
  p_oe_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tclk_oe == !$past(ext_mode)));

  // R3: no clock is driven while the pad is released
  p_quiet_when_released_r3: assert property (@(posedge clk) disable iff (rst)
    !tclk_oe |-> !tclk_out);

endmodule

// File: tb/tb_tx_clk_source.sv
module tb_tx_clk_source;

  localparam int unsigned WINP = 16;
  localparam int unsigned LAG_EXT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_mode = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       valid_on_fall = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       data_pos = 1'b0;
  logic       data_neg = 1'b0;
  logic       tclk_out, tclk_oe, tpos, tneg, bit_take, freq_alarm;

  int n_chk = 0;
  int n_bad = 0;

  // monitor state
  logic  mon_en = 1'b0;
  string mon_tag = "R4 R6";
  int    since = 1000;
  logic  last_tpos = 1'b0;
  logic  last_clk = 1'b0;
  logic  ext_q = 1'b0;
  int    ext_cnt = 0;
  int    ext_hi = 4;
  int    ext_lo = 4;

  always #4 clk = ~clk;

  tx_clk_source #(.WIN_PERIODS(WINP)) dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .rate_sel(rate_sel),
    .valid_on_fall(valid_on_fall), .ext_clk_in(ext_clk_in),
    .data_pos(data_pos), .data_neg(data_neg),
    .tclk_out(tclk_out), .tclk_oe(tclk_oe), .tpos(tpos), .tneg(tneg),
    .bit_take(bit_take), .freq_alarm(freq_alarm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Samples outputs, tracks launch-side clock transitions, drives the
  // external clock and the next data symbol (always the inverse of tpos).
  always @(negedge clk) begin
    int   now;
    int   lag;
    logic changed;
    logic lvl;
    lvl = valid_on_fall;
    if (!rst) begin
      now     = (since >= 1000) ? 1000 : since + 1;
      lag     = ext_mode ? LAG_EXT : 1;
      changed = (tpos != last_tpos);
      if (mon_en && (changed || now == lag)) begin
        check(changed == (now == lag) && bit_take == changed, mon_tag,
              int'(changed) * 10 + int'(bit_take), int'(now == lag) * 11);
      end
      since = now;
      if (!ext_mode && tclk_out != last_clk && tclk_out == lvl) since = 0;
    end
    ext_cnt++;
    if (ext_cnt >= (ext_q ? ext_hi : ext_lo)) begin
      ext_cnt = 0;
      ext_q   = ~ext_q;
      if (ext_mode && ext_q == lvl) since = 0;
    end
    ext_clk_in <= ext_q;
    data_pos   <= ~tpos;
    data_neg   <= tpos;
    last_tpos  = tpos;
    last_clk   = tclk_out;
  end

  task automatic configure(input logic m, input logic [2:0] c, input logic ef,
                           input logic en, input string tag);
    mon_en = 1'b0;
    @(negedge clk);
    ext_mode      <= m;
    rate_sel      <= c;
    valid_on_fall <= ef;
    repeat (30) @(negedge clk);
    mon_tag = tag;
    mon_en  = en;
  endtask

  task automatic measure_period(output int n);
    bit seen0;
    seen0 = 0;
    while (!(tclk_out === 1'b1 && last_clk === 1'b0)) @(negedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (!tclk_out) seen0 = 1;
      else if (seen0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual cycles %0d expected completion earlier", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per;
    int exp_per;
    bit ok;

    // R10: reset state
    repeat (5) @(negedge clk);
    check({tclk_out, tclk_oe, tpos, tneg, bit_take, freq_alarm} == 6'b0, "R10 reset",
          int'({tclk_out, tclk_oe, tpos, tneg, bit_take, freq_alarm}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(tclk_oe == 1'b1, "R3 oe internal", int'(tclk_oe), 1);

    // R1 / R2 period sweep with launch monitoring on both edge choices (R4, R6)
    for (int ef = 0; ef < 2; ef++) begin
      for (int c = 0; c < 8; c++) begin
        configure(1'b0, 3'(c), 1'(ef), 1'b1, "R4 R6 internal launch");
        measure_period(per);
        exp_per = 4 << ((c < 6) ? c : 5);
        check(per == exp_per, (c < 6) ? "R1 period" : "R2 folded period", per, exp_per);
        measure_period(per);
      end
    end

    // R9: restart drops the clock and the first rise comes half a period later
    configure(1'b0, 3'd3, 1'b0, 1'b0, "");
    repeat (37) @(negedge clk);
    rate_sel <= 3'd7;
    ok = 1;
    for (int i = 1; i <= 65; i++) begin
      @(negedge clk);
      if (tclk_out != (i == 65)) ok = 0;
    end
    check(ok, "R9 restart phase", int'(ok), 1);
    measure_period(per);
    check(per == 128, "R2 period after restart", per, 128);

    // R8: an out-of-band external clock is ignored in internal mode
    ext_hi = 3; ext_lo = 3;
    configure(1'b0, 3'd1, 1'b0, 1'b0, "");
    ok = 1;
    repeat (600) begin
      @(negedge clk);
      if (freq_alarm) ok = 0;
    end
    check(ok, "R8 alarm low internal", int'(freq_alarm), 0);

    // R3 / R5: external mode launch timing on both edge choices
    for (int ef = 0; ef < 2; ef++) begin
      ext_hi = 4; ext_lo = 4;
      configure(1'b1, 3'd1, 1'(ef), 1'b1, "R5 R6 external launch");
      ok = 1;
      repeat (300) begin
        @(negedge clk);
        if (tclk_oe || tclk_out) ok = 0;
      end
      check(ok, "R3 pad released", int'({tclk_oe, tclk_out}), 0);
      ext_hi = 5; ext_lo = 4;
      repeat (300) @(negedge clk);
    end
    mon_en = 1'b0;

    // R7: frequency window at code 1 (window 128 cycles, band 14..18)
    begin
      int hi_t [5] = '{4, 3, 5, 5, 6};
      int lo_t [5] = '{4, 3, 5, 4, 5};
      int bad_t[5] = '{0, 1, 1, 0, 1};
      for (int k = 0; k < 5; k++) begin
        ext_hi = hi_t[k]; ext_lo = lo_t[k];
        repeat (3 * 128 + 10) @(negedge clk);
        check(freq_alarm == 1'(bad_t[k]), "R7 code 1 window", int'(freq_alarm), bad_t[k]);
      end
    end

    // R7 at code 4 (window 1024 cycles)
    ext_hi = 32; ext_lo = 32;
    configure(1'b1, 3'd4, 1'b0, 1'b0, "");
    repeat (3 * 1024 + 10) @(negedge clk);
    check(freq_alarm == 1'b0, "R7 code 4 nominal", int'(freq_alarm), 0);
    ext_hi = 26; ext_lo = 26;
    repeat (3 * 1024 + 10) @(negedge clk);
    check(freq_alarm == 1'b1, "R7 code 4 fast", int'(freq_alarm), 1);

    // R9: mode change clears the alarm
    configure(1'b0, 3'd4, 1'b0, 1'b0, "");
    check(freq_alarm == 1'b0, "R9 mode change clears", int'(freq_alarm), 0);

    // R2 / R9: restart coinciding with window end, codes 6 and 7 (window 2048)
    ext_hi = 3; ext_lo = 3;
    configure(1'b1, 3'd6, 1'b0, 1'b0, "");
    repeat (3 * 2048 + 10) @(negedge clk);
    check(freq_alarm == 1'b1, "R2 R7 slowest window alarm", int'(freq_alarm), 1);
    rate_sel <= 3'd7;
    for (int t = 0; t < 4; t++) begin
      ok = 1;
      repeat (2048) begin
        @(negedge clk);
        if (freq_alarm) ok = 0;
      end
      check(ok, "R9 restart beats window end", int'(!ok), 0);
      rate_sel <= (rate_sel == 3'd7) ? 3'd6 : 3'd7;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule